// File: doc/BRIEF.md
# Stereo Gain Register Arbiter with Automatic Level Control

This block owns the left and right gain codes of a stereo input front end. In manual mode a host register write to a gain word reaches the active gain on the next clock. Automatic level control (ALC) can be switched on by a control register bit or by a pin. While it runs, the active gains follow a gain value computed outside this block. The host can still write gains during ALC. Attenuation codes (0x00 to 0x7F) take effect at once. Amplification codes (0x80 to 0xFF) are only kept as the last written value.

The block also handles the edges of ALC operation. On entry it requests soft mute, loads the left channel's gain into both channels as the common start value, and then releases mute. On exit it mutes again and marks each channel as pending restore. Each channel then returns to its most recent host-written gain on its own zero-crossing strobe, or on a shared timeout tick if that comes first.

A set of ALC parameter registers (timing, limit, reference) is held here as well. These registers are locked while the sequencer is away from idle. They power up to default values, so an ALC run started only from the pin uses the defaults.

Top module: `stereo_gain_arb`

## Requirements
- R1: After reset, ALC is off, both gains equal 0x88, soft_mute, param_lock and restore_pend are 0, and the parameter outputs hold their defaults: timing 0x05, limit 0x0A, reference 0xE1.
- R2: Register addresses are 0 left gain, 1 right gain, 2 control (bit 0 is the ALC enable), 3 timing, 4 limit and 5 reference. With ALC off and no restore pending, a gain write appears on that channel's gain output one cycle later.
- R3: While alc_active is 1, a gain write with a code of 0x80 or above leaves that channel's active gain unchanged. That code becomes the value the channel restores after ALC ends.
- R4: While alc_active is 1, a gain write with a code of 0x7F or below sets that channel's gain one cycle later. It takes priority over an ALC gain presented in the same cycle.
- R5: While alc_active is 1 and no write reaches a channel, alc_gain_vld loads alc_gain_l and alc_gain_r into the gains one cycle later.
- R6: In the first cycle that alc_active is 1, both gains equal the left gain held just before ALC was entered.
- R7: soft_mute is 1 in the cycle where alc_active rises and in the cycle where it falls. It returns to 0 within two cycles after either change.
- R8: When alc_active falls, both restore_pend bits are set, and ALC gain updates are then ignored. A channel's pending restore loads its last host-written gain (including writes made while pending) on its zero-crossing strobe or on tmo_tick, and then clears its bit.
- R9: param_lock is 1 whenever the ALC sequence is away from idle. Writes to the timing, limit and reference registers are ignored while it is 1.
- R10: ALC parameter outputs hold their defaults until written. A write made while unlocked is shown from the next cycle.
- R11: ALC is requested when either the control bit or alc_pin is 1. Either source alone starts the entry sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Register write data |
| alc_pin | input | 1 | ALC enable pin |
| alc_gain_l | input | 8 | ALC-computed left gain |
| alc_gain_r | input | 8 | ALC-computed right gain |
| alc_gain_vld | input | 1 | ALC gain update strobe |
| zc_l | input | 1 | Left zero-crossing strobe |
| zc_r | input | 1 | Right zero-crossing strobe |
| tmo_tick | input | 1 | Restore timeout tick |
| gain_l | output | 8 | Active left gain code |
| gain_r | output | 8 | Active right gain code |
| soft_mute | output | 1 | Soft-mute request |
| alc_active | output | 1 | ALC gain tracking active |
| param_lock | output | 1 | ALC parameter registers locked |
| restore_pend | output | 2 | Pending restore, bit 0 left, bit 1 right |
| alc_timing | output | 8 | Effective ALC timing parameter |
| alc_limit | output | 8 | Effective ALC limit parameter |
| alc_ref | output | 8 | Effective ALC reference level |

## Verification
The hardest state to reach is a pending restore in which the stored value differs from what is on the output. Reaching it takes a full entry sequence. During ALC the stimulus writes an amplification code that is held back, lets ALC gains overwrite the outputs, and then leaves ALC. While the restore is pending, the bench adds one more host write, presents ALC updates that must be ignored, and then fires a zero crossing on only one channel and the timeout afterwards. This separates the two release paths and shows that each channel restores its newest stored value.

// File: rtl/gainarb_pkg.sv
package gainarb_pkg;
    localparam int GAIN_W = 8;
    localparam int ADDR_W = 3;

    typedef logic [GAIN_W-1:0] gain_t;

    typedef enum logic [ADDR_W-1:0] {
        RA_GAIN_L = 3'd0,
        RA_GAIN_R = 3'd1,
        RA_CTRL   = 3'd2,
        RA_TIMING = 3'd3,
        RA_LIMIT  = 3'd4,
        RA_REF    = 3'd5
    } reg_addr_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_MUTE_IN,
        SQ_ON_HOLD,
        SQ_RUN,
        SQ_MUTE_OUT,
        SQ_OFF_HOLD
    } seq_state_e;

    typedef struct packed {
        gain_t timing;
        gain_t limit;
        gain_t ref_lvl;
    } alc_cfg_t;

    localparam gain_t    GAIN_RST    = 8'h88;
    localparam alc_cfg_t CFG_DEFAULT = '{timing: 8'h05, limit: 8'h0A, ref_lvl: 8'hE1};

    function automatic logic is_attn(input gain_t code);
        return ~code[GAIN_W-1];
    endfunction
endpackage

// File: rtl/gainarb_seq.sv
module gainarb_seq
    import gainarb_pkg::*;
#(
    parameter int MUTE_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic soft_mute,
    output logic alc_on,
    output logic load_start,
    output logic exit_pulse,
    output logic lock
);
    localparam int CW = $clog2(MUTE_CYC) + 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(MUTE_CYC - 1);

    seq_state_e    state;
    logic [CW-1:0] cnt;
    logic          cnt_done;

    assign cnt_done = (cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    cnt <= '0;
                    if (req) state <= SQ_MUTE_IN;
                end
                SQ_MUTE_IN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt_done) begin
                        state <= SQ_ON_HOLD;
                        cnt   <= '0;
                    end
                end
                SQ_ON_HOLD: state <= SQ_RUN;
                SQ_RUN: begin
                    cnt <= '0;
                    if (!req) state <= SQ_MUTE_OUT;
                end
                SQ_MUTE_OUT: begin
                    cnt <= cnt + 1'b1;
                    if (cnt_done) begin
                        state <= SQ_OFF_HOLD;
                        cnt   <= '0;
                    end
                end
                SQ_OFF_HOLD: state <= SQ_IDLE;
                default:     state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        alc_on     = (state == SQ_ON_HOLD) || (state == SQ_RUN) || (state == SQ_MUTE_OUT);
        soft_mute  = (state == SQ_MUTE_IN) || (state == SQ_ON_HOLD) ||
                     (state == SQ_MUTE_OUT) || (state == SQ_OFF_HOLD);
        load_start = (state == SQ_MUTE_IN) && cnt_done;
        exit_pulse = (state == SQ_MUTE_OUT) && cnt_done;
        lock       = (state != SQ_IDLE);
    end

    // R7: mute surrounds every change of the ALC active state
    a_r7_mute_at_entry: assert property (@(posedge clk) disable iff (rst)
        $rose(alc_on) |-> soft_mute);
    a_r7_mute_at_exit: assert property (@(posedge clk) disable iff (rst)
        $fell(alc_on) |-> soft_mute);
    // R9: lock covers the whole active window
    a_r9_lock_while_on: assert property (@(posedge clk) disable iff (rst)
        alc_on |-> lock);
endmodule

// File: rtl/gainarb_params.sv
module gainarb_params
    import gainarb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  gain_t    wdata,
    input  logic     lock,
    output alc_cfg_t cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_DEFAULT;
        end else if (wr_en && !lock) begin
            case (reg_addr_e'(addr))
                RA_TIMING: cfg.timing  <= wdata;
                RA_LIMIT:  cfg.limit   <= wdata;
                RA_REF:    cfg.ref_lvl <= wdata;
                default:   ;
            endcase
        end
    end

    // R9: locked writes leave every parameter untouched
    a_r9_locked_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (lock && wr_en) |=> (cfg == $past(cfg)));
endmodule

// File: rtl/gainarb_chan.sv
module gainarb_chan
    import gainarb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  gain_t wdata,
    input  logic  alc_on,
    input  logic  load_start,
    input  gain_t start_val,
    input  logic  alc_vld,
    input  gain_t alc_gain,
    input  logic  exit_pulse,
    input  logic  zc,
    input  logic  tmo,
    output gain_t gain,
    output logic  pend
);
    gain_t act_q;
    gain_t shadow_q;
    logic  pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q    <= GAIN_RST;
            shadow_q <= GAIN_RST;
            pend_q   <= 1'b0;
        end else begin
            if (wr_en) shadow_q <= wdata;

            if (load_start) begin
                act_q  <= start_val;
                pend_q <= 1'b0;
            end else if (pend_q) begin
                if (zc || tmo) begin
                    act_q  <= wr_en ? wdata : shadow_q;
                    pend_q <= 1'b0;
                end
            end else if (alc_on) begin
                if (wr_en && is_attn(wdata)) act_q <= wdata;
                else if (alc_vld)            act_q <= alc_gain;
            end else if (wr_en) begin
                act_q <= wdata;
            end

            if (exit_pulse) pend_q <= 1'b1;
        end
    end

    assign gain = act_q;
    assign pend = pend_q;

    // R3: amplification write during ALC does not reach the output
    a_r3_amp_write_held: assert property (@(posedge clk) disable iff (rst)
        (alc_on && wr_en && !is_attn(wdata) && !alc_vld) |=> $stable(act_q));
    // R4: attenuation write during ALC wins over the ALC gain
    a_r4_attn_override: assert property (@(posedge clk) disable iff (rst)
        (alc_on && wr_en && is_attn(wdata)) |=> (act_q == $past(wdata)));
    // R8: while a restore waits, nothing else moves the gain
    a_r8_hold_while_pend: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !zc && !tmo && !load_start) |=> $stable(act_q));
    a_r8_restore_value: assert property (@(posedge clk) disable iff (rst)
        (pend_q && (zc || tmo) && !wr_en && !load_start) |=> (act_q == $past(shadow_q) && !pend_q));
endmodule

// File: rtl/stereo_gain_arb.sv
module stereo_gain_arb
    import gainarb_pkg::*;
#(
    parameter int MUTE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_wr,
    input  logic [2:0] host_addr,
    input  logic [7:0] host_wdata,
    input  logic       alc_pin,
    input  logic [7:0] alc_gain_l,
    input  logic [7:0] alc_gain_r,
    input  logic       alc_gain_vld,
    input  logic       zc_l,
    input  logic       zc_r,
    input  logic       tmo_tick,
    output logic [7:0] gain_l,
    output logic [7:0] gain_r,
    output logic       soft_mute,
    output logic       alc_active,
    output logic       param_lock,
    output logic [1:0] restore_pend,
    output logic [7:0] alc_timing,
    output logic [7:0] alc_limit,
    output logic [7:0] alc_ref
);
    localparam int NCH = 2;

    logic     ctrl_en_q;
    logic     alc_req;
    logic     alc_on, load_start, exit_pulse, lock;
    alc_cfg_t cfg;
    logic     ch_wr  [NCH];
    gain_t    ch_alc [NCH];
    logic     ch_zc  [NCH];
    gain_t    ch_gain[NCH];
    logic     ch_pend[NCH];

    always_ff @(posedge clk) begin
        if (rst)                                            ctrl_en_q <= 1'b0;
        else if (host_wr && reg_addr_e'(host_addr) == RA_CTRL) ctrl_en_q <= host_wdata[0];
    end

    assign alc_req = ctrl_en_q | alc_pin;

    gainarb_seq #(.MUTE_CYC(MUTE_CYC)) seq_i (
        .clk(clk), .rst(rst), .req(alc_req),
        .soft_mute(soft_mute), .alc_on(alc_on),
        .load_start(load_start), .exit_pulse(exit_pulse), .lock(lock)
    );

    gainarb_params params_i (
        .clk(clk), .rst(rst), .wr_en(host_wr), .addr(host_addr),
        .wdata(host_wdata), .lock(lock), .cfg(cfg)
    );

    always_comb begin
        ch_wr[0]  = host_wr && (reg_addr_e'(host_addr) == RA_GAIN_L);
        ch_wr[1]  = host_wr && (reg_addr_e'(host_addr) == RA_GAIN_R);
        ch_alc[0] = alc_gain_l;
        ch_alc[1] = alc_gain_r;
        ch_zc[0]  = zc_l;
        ch_zc[1]  = zc_r;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        gainarb_chan chan_i (
            .clk(clk), .rst(rst),
            .wr_en(ch_wr[c]), .wdata(host_wdata),
            .alc_on(alc_on), .load_start(load_start), .start_val(ch_gain[0]),
            .alc_vld(alc_gain_vld), .alc_gain(ch_alc[c]),
            .exit_pulse(exit_pulse), .zc(ch_zc[c]), .tmo(tmo_tick),
            .gain(ch_gain[c]), .pend(ch_pend[c])
        );
        assign restore_pend[c] = ch_pend[c];
    end

    assign gain_l     = ch_gain[0];
    assign gain_r     = ch_gain[1];
    assign alc_active = alc_on;
    assign param_lock = lock;
    assign alc_timing = cfg.timing;
    assign alc_limit  = cfg.limit;
    assign alc_ref    = cfg.ref_lvl;

    // R6: both channels start ALC from the same gain
    a_r6_common_start: assert property (@(posedge clk) disable iff (rst)
        $rose(alc_active) |-> (gain_l == gain_r));
    // R8: leaving ALC marks both channels for restore
    a_r8_pend_on_exit: assert property (@(posedge clk) disable iff (rst)
        $fell(alc_active) |-> (restore_pend == 2'b11));
endmodule

// File: tb/stereo_gain_arb_tb.sv
module stereo_gain_arb_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;
    localparam int  NVEC       = 6;
    // {addr, data, expected left, expected right}
    localparam logic [31:0] VEC [NVEC] = '{
        {8'd0, 8'h40, 8'h40, 8'h88},
        {8'd1, 8'hC0, 8'h40, 8'hC0},
        {8'd0, 8'h80, 8'h80, 8'hC0},
        {8'd1, 8'h7F, 8'h80, 8'h7F},
        {8'd0, 8'h90, 8'h90, 8'h7F},
        {8'd1, 8'hA0, 8'h90, 8'hA0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       alc_pin = 1'b0;
    logic [7:0] alc_gain_l = '0, alc_gain_r = '0;
    logic       alc_gain_vld = 1'b0;
    logic       zc_l = 1'b0, zc_r = 1'b0, tmo_tick = 1'b0;
    logic [7:0] gain_l, gain_r, alc_timing, alc_limit, alc_ref;
    logic       soft_mute, alc_active, param_lock;
    logic [1:0] restore_pend;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stereo_gain_arb dut_i (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .alc_pin(alc_pin),
        .alc_gain_l(alc_gain_l), .alc_gain_r(alc_gain_r), .alc_gain_vld(alc_gain_vld),
        .zc_l(zc_l), .zc_r(zc_r), .tmo_tick(tmo_tick),
        .gain_l(gain_l), .gain_r(gain_r), .soft_mute(soft_mute),
        .alc_active(alc_active), .param_lock(param_lock), .restore_pend(restore_pend),
        .alc_timing(alc_timing), .alc_limit(alc_limit), .alc_ref(alc_ref)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // called at a negedge, returns at the negedge after the write edge
    task automatic hwrite(input logic [2:0] a, input logic [7:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic wait_active(input logic val, input string tag);
        int k;
        for (k = 0; k < 40; k++) begin
            if (alc_active == val) break;
            @(negedge clk);
        end
        check(tag, {31'd0, alc_active}, {31'd0, val});
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 gain_l", gain_l, 8'h88);
        check("R1 gain_r", gain_r, 8'h88);
        check("R1 mute/lock/active/pend", {soft_mute, param_lock, alc_active, restore_pend}, 5'b0);
        check("R1 defaults", {alc_timing, alc_limit, alc_ref}, 24'h050AE1);

        // R2: manual mode vector walk
        for (int i = 0; i < NVEC; i++) begin
            hwrite(VEC[i][26:24], VEC[i][23:16]);
            check("R2 gain_l", gain_l, VEC[i][15:8]);
            check("R2 gain_r", gain_r, VEC[i][7:0]);
        end

        // R11 pin start, R10 defaults, R6 common start, R7 mute at entry
        alc_pin = 1'b1;
        @(negedge clk);
        check("R7 mute before active", {soft_mute, alc_active}, 2'b10);
        wait_active(1'b1, "R11 pin start");
        check("R7 mute at entry", soft_mute, 1'b1);
        check("R6 start left", gain_l, 8'h90);
        check("R6 start right", gain_r, 8'h90);
        check("R10 defaults in ALC", {alc_timing, alc_limit, alc_ref}, 24'h050AE1);
        check("R9 lock", param_lock, 1'b1);
        @(negedge clk);
        check("R7 mute released", soft_mute, 1'b0);

        // R5 ALC gain follows
        alc_gain_l = 8'hB0; alc_gain_r = 8'hB4; alc_gain_vld = 1'b1;
        @(negedge clk);
        alc_gain_vld = 1'b0;
        check("R5 follow l", gain_l, 8'hB0);
        check("R5 follow r", gain_r, 8'hB4);

        // R3 amplification write held
        hwrite(3'd1, 8'hC4);
        check("R3 amp held", gain_r, 8'hB4);

        // R4 attenuation override in same cycle as ALC update
        alc_gain_l = 8'hB8; alc_gain_r = 8'hB9; alc_gain_vld = 1'b1;
        hwrite(3'd0, 8'h30);
        alc_gain_vld = 1'b0;
        check("R4 attn override", gain_l, 8'h30);
        check("R5 other channel follows", gain_r, 8'hB9);

        // R9 locked parameter write
        hwrite(3'd4, 8'h55);
        check("R9 locked write ignored", alc_limit, 8'h0A);

        // R8 exit and restore
        alc_pin = 1'b0;
        @(negedge clk);
        wait_active(1'b0, "R8 exit");
        check("R7 mute at exit", soft_mute, 1'b1);
        check("R8 pend set", restore_pend, 2'b11);
        alc_gain_l = 8'h11; alc_gain_r = 8'h11; alc_gain_vld = 1'b1;
        @(negedge clk);
        alc_gain_vld = 1'b0;
        check("R8 alc ignored l", gain_l, 8'h30);
        check("R8 alc ignored r", gain_r, 8'hB9);
        hwrite(3'd0, 8'hD0);
        check("R8 write during pend held", gain_l, 8'h30);
        zc_l = 1'b1;
        @(negedge clk);
        zc_l = 1'b0;
        check("R8 zc restore l", gain_l, 8'hD0);
        check("R8 r still pending", {restore_pend, gain_r}, {2'b10, 8'hB9});
        tmo_tick = 1'b1;
        @(negedge clk);
        tmo_tick = 1'b0;
        check("R3 R8 timeout restores amp write", gain_r, 8'hC4);
        check("R8 pend clear", restore_pend, 2'b00);
        check("R7 mute off after exit", soft_mute, 1'b0);
        check("R9 unlocked", param_lock, 1'b0);

        // R10 written value used, R11 register start, R6 mismatched start
        hwrite(3'd3, 8'h21);
        check("R10 written timing", alc_timing, 8'h21);
        hwrite(3'd0, 8'h50);
        hwrite(3'd1, 8'h60);
        check("R2 manual again", {gain_l, gain_r}, 16'h5060);
        hwrite(3'd2, 8'h01);
        wait_active(1'b1, "R11 register start");
        check("R6 common start", {gain_l, gain_r}, 16'h5050);
        check("R10 written in ALC", alc_timing, 8'h21);
        hwrite(3'd2, 8'h00);
        wait_active(1'b0, "R11 register stop");
        @(negedge clk);
        tmo_tick = 1'b1;
        @(negedge clk);
        tmo_tick = 1'b0;
        check("R8 timeout both", {gain_l, gain_r}, 16'h5060);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule